// File: doc/BRIEF.md
# Software Transfer Trigger Controller

This block is the software-start front end of a descriptor-driven transfer engine. A processor writes a descriptor offset into a trigger register, and the block then raises a request toward the engine's arbiter. The request carries that offset and the resolved descriptor address, which is a programmable base plus the offset. While a transfer started this way is running, the block remembers that it is busy and refuses new triggers. It follows any chained descriptor the engine jumps to, and on completion it records a done flag. That flag can drive an interrupt line.

The engine reports completion through three pulse inputs: normal end, abnormal end, and a stop that waits for a new trigger. On a normal end it also supplies the interrupt flag taken from the descriptor that finished. The processor reads and writes four word registers over a plain single-cycle port. Read data is combinational on the selected address.

Top module: `swtrig_ctrl`

## Requirements
- R1: After reset, every register reads zero: base (address 0), trigger (address 1), config (address 2). The request valid output and the interrupt output are low.
- R2: While a request is outstanding, `req_ptr` equals the stored offset and `req_addr` equals the base register plus the zero-extended offset.
- R3: A write to address 1 while not busy stores `cpu_wdata[PTR_W-1:0]` as the offset. From the next cycle, the busy bit (trigger bit PTR_W, bit 16 by default) reads 1 and `req_valid` is high.
- R4: A write to address 1 while busy has no effect. The offset and the busy bit keep their values.
- R5: The busy bit returns to 0 after a one-cycle pulse on `end_ok`, `end_err` or `end_wait` while busy.
- R6: A `chain_vld` pulse while busy replaces the stored offset with `chain_ptr`. A pulse while idle leaves the offset unchanged.
- R7: `req_valid` stays high until a cycle with `req_ready` high. After that it stays low for the rest of the same transfer.
- R8: The done bit (trigger bit PTR_W+1, bit 17 by default) is set by `end_ok` with `end_irq` high while busy. It is not set by `end_ok` without the flag, nor by `end_err`.
- R9: A write to address 3 with `cpu_wdata[0]`=1 clears the done bit. The same write with bit 0 at 0 leaves the done bit unchanged.
- R10: When a setting end event and a clear command arrive in the same cycle, the done bit ends up 1.
- R11: `irq` is high exactly when config bit 0 (interrupt enable) is 1 and the done bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_addr | input | 2 | Register word select |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data for `cpu_addr` |
| end_ok | input | 1 | Transfer ended normally (pulse) |
| end_irq | input | 1 | Interrupt flag of the finishing descriptor, qualifies `end_ok` |
| end_err | input | 1 | Transfer ended abnormally (pulse) |
| end_wait | input | 1 | Transfer stopped awaiting a new trigger (pulse) |
| chain_vld | input | 1 | Chain start to a new descriptor (pulse) |
| chain_ptr | input | PTR_W | Offset of the chained descriptor |
| req_valid | output | 1 | Software request to the arbiter |
| req_ready | input | 1 | Arbiter accepts the request |
| req_ptr | output | PTR_W | Offset of the requested descriptor |
| req_addr | output | ADDR_W | Base plus offset |
| irq | output | 1 | Interrupt line |

## Verification
The bench writes a second trigger while busy. A design that accepted it would change the offset or re-raise the request. It holds `req_ready` low for several cycles and then shows a single accept, which catches a request that drops early or comes back after acceptance. It ends transfers in each of the three ways, with and without the descriptor flag, to expose a done bit set on the wrong event. It also sends a clear command in the same cycle as a flagged end, where a design with the wrong priority would lose the completion.

// File: rtl/swtrig_pkg.sv
package swtrig_pkg;

    localparam int DATA_W = 32;

    // Register word select
    typedef enum logic [1:0] {
        SEL_BASE = 2'd0,
        SEL_TRIG = 2'd1,
        SEL_CFG  = 2'd2,
        SEL_CMD  = 2'd3
    } reg_sel_e;

    localparam int CFG_IE_BIT  = 0;
    localparam int CMD_CLR_BIT = 0;

    // End-of-transfer events from the engine
    typedef struct packed {
        logic ok;
        logic err;
        logic hold;
        logic flag;
    } end_evt_t;

    function automatic logic evt_any(end_evt_t e);
        return e.ok | e.err | e.hold;
    endfunction

    function automatic logic evt_sets_done(end_evt_t e);
        return e.ok & e.flag;
    endfunction

endpackage

// File: rtl/swtrig_regs.sv
module swtrig_regs
    import swtrig_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [ADDR_W-1:0] base,
    output logic              ie,
    output logic              trig_wr,
    output logic              clr_cmd
);
    reg_sel_e sel;
    assign sel = reg_sel_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            base <= '0;
            ie   <= 1'b0;
        end else if (wr) begin
            if (sel == SEL_BASE) base <= wdata[ADDR_W-1:0];
            if (sel == SEL_CFG)  ie   <= wdata[CFG_IE_BIT];
        end
    end

    assign trig_wr = wr && (sel == SEL_TRIG);
    assign clr_cmd = wr && (sel == SEL_CMD) && wdata[CMD_CLR_BIT];
endmodule

// File: rtl/swtrig_state.sv
module swtrig_state
    import swtrig_pkg::*;
#(
    parameter int PTR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig_wr,
    input  logic [PTR_W-1:0] trig_ptr,
    input  logic             clr_cmd,
    input  end_evt_t         evt,
    input  logic             chain_vld,
    input  logic [PTR_W-1:0] chain_ptr,
    input  logic             req_ready,
    output logic             pending,
    output logic             done,
    output logic [PTR_W-1:0] ptr,
    output logic             req_valid
);
    logic accept;
    assign accept = trig_wr && !pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending   <= 1'b0;
            ptr       <= '0;
            req_valid <= 1'b0;
        end else if (accept) begin
            pending   <= 1'b1;
            ptr       <= trig_ptr;
            req_valid <= 1'b1;
        end else if (pending) begin
            if (evt_any(evt)) begin
                pending   <= 1'b0;
                req_valid <= 1'b0;
            end else begin
                if (chain_vld) ptr <= chain_ptr;
                if (req_valid && req_ready) req_valid <= 1'b0;
            end
        end
    end

    // Set wins over clear
    always_ff @(posedge clk) begin
        if (rst)                                done <= 1'b0;
        else if (pending && evt_sets_done(evt)) done <= 1'b1;
        else if (clr_cmd)                       done <= 1'b0;
    end
endmodule

// File: rtl/swtrig_addr.sv
module swtrig_addr #(
    parameter int ADDR_W = 32,
    parameter int PTR_W  = 16
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [PTR_W-1:0]  ptr,
    output logic [ADDR_W-1:0] addr
);
    assign addr = base + ADDR_W'(ptr);
endmodule

// File: rtl/swtrig_ctrl.sv
module swtrig_ctrl
    import swtrig_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PTR_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_wr,
    input  logic [1:0]        cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              end_ok,
    input  logic              end_irq,
    input  logic              end_err,
    input  logic              end_wait,
    input  logic              chain_vld,
    input  logic [PTR_W-1:0]  chain_ptr,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [PTR_W-1:0]  req_ptr,
    output logic [ADDR_W-1:0] req_addr,
    output logic              irq
);
    localparam int PEND_BIT = PTR_W;
    localparam int DONE_BIT = PTR_W + 1;

    logic [ADDR_W-1:0] base;
    logic              ie, trig_wr, clr_cmd;
    logic              pending, done;
    logic [PTR_W-1:0]  ptr;
    end_evt_t          evt;

    assign evt = '{ok: end_ok, err: end_err, hold: end_wait, flag: end_irq};

    swtrig_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .wr(cpu_wr), .addr(cpu_addr), .wdata(cpu_wdata),
        .base(base), .ie(ie), .trig_wr(trig_wr), .clr_cmd(clr_cmd)
    );

    swtrig_state #(.PTR_W(PTR_W)) u_state (
        .clk(clk), .rst(rst), .trig_wr(trig_wr), .trig_ptr(cpu_wdata[PTR_W-1:0]),
        .clr_cmd(clr_cmd), .evt(evt), .chain_vld(chain_vld), .chain_ptr(chain_ptr),
        .req_ready(req_ready), .pending(pending), .done(done), .ptr(ptr),
        .req_valid(req_valid)
    );

    swtrig_addr #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_addr (
        .base(base), .ptr(ptr), .addr(req_addr)
    );

    assign req_ptr = ptr;
    assign irq     = ie & done;

    always_comb begin
        cpu_rdata = '0;
        case (reg_sel_e'(cpu_addr))
            SEL_BASE: cpu_rdata = DATA_W'(base);
            SEL_TRIG: begin
                cpu_rdata[PTR_W-1:0] = ptr;
                cpu_rdata[PEND_BIT]  = pending;
                cpu_rdata[DONE_BIT]  = done;
            end
            SEL_CFG:  cpu_rdata[CFG_IE_BIT] = ie;
            default:  cpu_rdata = '0;
        endcase
    end
endmodule

// File: rtl/swtrig_ctrl_chk.sv
module swtrig_ctrl_chk #(
    parameter int PTR_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             cpu_wr,
    input logic [1:0]       cpu_addr,
    input logic             end_ok,
    input logic             end_irq,
    input logic             end_err,
    input logic             end_wait,
    input logic             chain_vld,
    input logic             req_valid,
    input logic             req_ready,
    input logic             pending,
    input logic             done,
    input logic [PTR_W-1:0] ptr,
    input logic             irq
);
    assert_trigger_starts_R3: assert property (@(posedge clk) disable iff (rst)
        (!pending && cpu_wr && cpu_addr == 2'd1) |=> (pending && req_valid));

    assert_busy_write_dropped_R4: assert property (@(posedge clk) disable iff (rst)
        (pending && cpu_wr && cpu_addr == 2'd1 && !chain_vld) |=> (ptr == $past(ptr)));

    assert_busy_needs_end_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(pending) |-> $past(end_ok || end_err || end_wait));

    assert_valid_held_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready && !end_ok && !end_err && !end_wait) |=> req_valid);

    assert_valid_only_busy_R7: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> pending);

    assert_done_set_R8: assert property (@(posedge clk) disable iff (rst)
        (pending && end_ok && end_irq) |=> done);

    assert_irq_needs_done_R11: assert property (@(posedge clk) disable iff (rst)
        irq |-> done);
endmodule

bind swtrig_ctrl swtrig_ctrl_chk #(.PTR_W(PTR_W)) u_chk (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .end_ok(end_ok), .end_irq(end_irq), .end_err(end_err), .end_wait(end_wait),
    .chain_vld(chain_vld), .req_valid(req_valid), .req_ready(req_ready),
    .pending(pending), .done(done), .ptr(ptr), .irq(irq)
);

// File: tb/swtrig_ctrl_tb.sv
module swtrig_ctrl_tb;
    localparam int ADDR_W = 32;
    localparam int PTR_W  = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cpu_wr = 1'b0;
    logic [1:0]        cpu_addr = 2'd0;
    logic [31:0]       cpu_wdata = '0;
    logic [31:0]       cpu_rdata;
    logic              end_ok = 1'b0, end_irq = 1'b0, end_err = 1'b0, end_wait = 1'b0;
    logic              chain_vld = 1'b0;
    logic [PTR_W-1:0]  chain_ptr = '0;
    logic              req_valid, req_ready = 1'b0;
    logic [PTR_W-1:0]  req_ptr;
    logic [ADDR_W-1:0] req_addr;
    logic              irq;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] base_v;

    always #4 clk = ~clk;

    swtrig_ctrl #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_dut (
        .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .end_ok(end_ok),
        .end_irq(end_irq), .end_err(end_err), .end_wait(end_wait),
        .chain_vld(chain_vld), .chain_ptr(chain_ptr), .req_valid(req_valid),
        .req_ready(req_ready), .req_ptr(req_ptr), .req_addr(req_addr), .irq(irq)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        cpu_addr = a;
        #1;
        d = cpu_rdata;
    endtask

    task automatic end_pulse(input logic ok, input logic err, input logic wt, input logic flag);
        @(negedge clk);
        end_ok = ok; end_err = err; end_wait = wt; end_irq = flag;
        @(negedge clk);
        end_ok = 0; end_err = 0; end_wait = 0; end_irq = 0;
    endtask

    task automatic accept_req();
        @(negedge clk); req_ready = 1'b1;
        @(negedge clk); req_ready = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(2'd0, d); check("R1 base", d, 0);
        rd(2'd1, d); check("R1 trigger", d, 0);
        rd(2'd2, d); check("R1 config", d, 0);
        check("R1 req_valid", req_valid, 0);
        check("R1 irq", irq, 0);
    endtask

    task automatic t_trigger_handshake();
        logic [31:0] d;
        base_v = 32'h1000_0000;
        cpu_write(2'd0, base_v);
        cpu_write(2'd1, 32'hABCD_0040);
        rd(2'd1, d); check("R3 busy+ptr", d, 32'h0001_0040);
        check("R3 req_valid", req_valid, 1);
        check("R2 req_ptr", req_ptr, 16'h0040);
        check("R2 req_addr", req_addr, base_v + 32'h40);
        for (int i = 0; i < 3; i++) @(negedge clk);
        check("R7 held without ready", req_valid, 1);
        accept_req();
        check("R7 dropped after accept", req_valid, 0);
        for (int i = 0; i < 3; i++) @(negedge clk);
        check("R7 not reissued", req_valid, 0);
        rd(2'd1, d); check("R7 still busy", d, 32'h0001_0040);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] d;
        cpu_write(2'd1, 32'h0000_0077);
        rd(2'd1, d); check("R4 write dropped", d, 32'h0001_0040);
        check("R4 no new request", req_valid, 0);
    endtask

    task automatic t_chain();
        logic [31:0] d;
        @(negedge clk); chain_vld = 1'b1; chain_ptr = 16'h0123;
        @(negedge clk); chain_vld = 1'b0;
        rd(2'd1, d); check("R6 chain replaces ptr", d, 32'h0001_0123);
        check("R2 addr after chain", req_addr, base_v + 32'h123);
        end_pulse(1, 0, 0, 0);
        rd(2'd1, d); check("R5 end_ok clears busy", d[16], 0);
        check("R8 no flag no done", d[17], 0);
        @(negedge clk); chain_vld = 1'b1; chain_ptr = 16'h0999;
        @(negedge clk); chain_vld = 1'b0;
        rd(2'd1, d); check("R6 idle chain ignored", d[15:0], 16'h0123);
    endtask

    task automatic t_err_wait();
        logic [31:0] d;
        cpu_write(2'd1, 32'h0000_0010);
        accept_req();
        end_pulse(0, 1, 0, 1);
        rd(2'd1, d); check("R5 end_err clears busy", d[16], 0);
        check("R8 err does not set done", d[17], 0);
        cpu_write(2'd1, 32'h0000_0011);
        end_pulse(0, 0, 1, 0);
        rd(2'd1, d); check("R5 end_wait clears busy", d[16], 0);
        check("R5 valid cleared", req_valid, 0);
    endtask

    task automatic t_done_irq();
        logic [31:0] d;
        cpu_write(2'd2, 32'h0);
        cpu_write(2'd1, 32'h0000_0020);
        accept_req();
        end_pulse(1, 0, 0, 1);
        rd(2'd1, d); check("R8 done set", d[17], 1);
        check("R11 irq masked", irq, 0);
        cpu_write(2'd2, 32'h1);
        check("R11 irq raised", irq, 1);
        cpu_write(2'd3, 32'h0000_0002);
        rd(2'd1, d); check("R9 bit0 clear keeps done", d[17], 1);
        cpu_write(2'd3, 32'h0000_0001);
        rd(2'd1, d); check("R9 clear done", d[17], 0);
        check("R11 irq falls", irq, 0);
    endtask

    task automatic t_collide();
        logic [31:0] d;
        cpu_write(2'd1, 32'h0000_0030);
        accept_req();
        @(negedge clk);
        end_ok = 1; end_irq = 1; cpu_wr = 1; cpu_addr = 2'd3; cpu_wdata = 32'h1;
        @(negedge clk);
        end_ok = 0; end_irq = 0; cpu_wr = 0;
        rd(2'd1, d); check("R10 set beats clear", d[17], 1);
        check("R11 irq after collide", irq, 1);
        cpu_write(2'd3, 32'h1);
        check("R9 clear after collide", irq, 0);
    endtask

    initial begin
        #(8 * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_trigger_handshake();
        t_busy_ignore();
        t_chain();
        t_err_wait();
        t_done_irq();
        t_collide();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule